// File: doc/BRIEF.md
# Serial Systematic CRC Encoder

This block appends a cyclic redundancy check to a serial message, one bit per clock. A single pulse on `start` arms it. The message then arrives most significant bit first, with each bit qualified by `din_valid`. Every accepted bit is copied to `dout` one cycle later. At the same time a linear feedback shift register divides the message by a generator polynomial that is fixed at elaboration.

Once the last message bit has been taken, the controller turns off the register's feedback. The register then works as a plain shift register and pushes its remainder onto `dout` on consecutive clocks. The receiver therefore sees one unbroken systematic codeword: the message followed by the check bits.

The controller has four named states:
- `ST_IDLE` waits for `start`.
- `ST_MSG` forwards message bits with feedback on.
- `ST_FCS` shifts out the check bits with feedback off.
- `ST_FIN` raises the completion flag.

Its transitions are:
- IDLE→MSG on `start`.
- MSG→FCS on the last valid message bit.
- FCS→FIN after the last check bit.
- FIN→IDLE unconditionally.

Top module: `crc_serial_enc`

## Requirements
- R1: A synchronous reset, applied at any time including mid-frame, leaves `dout_valid`, `done` and `dout` low on the next cycle, and the frame that follows encodes correctly.
- R2: Each message bit accepted with `din_valid` high appears on `dout` in the following cycle with `dout_valid` high. A cycle with `din_valid` low gives a cycle with `dout_valid` low and does not advance the encoder.
- R3: Right after the final message bit, exactly CRC_W check bits leave on consecutive cycles, most significant first. Together they equal the remainder of the message times x^CRC_W divided by the generator. The generator is x^CRC_W plus the low terms in CRC_POLY, where bit k of CRC_POLY is the coefficient of x^k.
- R4: With the default generator x^5+x^4+x^2+1 (CRC_POLY = 5'b10101) and 10-bit message 1010001101, the serial output is 101000110101110.
- R5: `done` is high for exactly one cycle, namely the cycle after the last check bit, with `dout_valid` low. `dout_valid` is high for exactly MSG_LEN+CRC_W cycles per frame.
- R6: A `start` pulse during a frame, in either the message or the check phase, has no effect on the output codeword.
- R7: A `start` raised in the same cycle that `done` is high begins a new frame. The register is cleared on start, so the new frame's check bits depend only on its own message.
- R8: Before `start`, `din` and `din_valid` are ignored: `dout_valid` stays low and the next frame is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a frame (honoured only when idle) |
| din | input | 1 | Serial message bit |
| din_valid | input | 1 | Qualifies `din` during the message phase |
| dout | output | 1 | Serial codeword bit |
| dout_valid | output | 1 | Qualifies `dout` |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The completion pulse and the acceptance of a new `start` can fall in the same cycle, because `done` is high while the controller is already back in `ST_IDLE`. The bench watches for `done` at the sampling point and raises `start` in that very cycle. It then streams a second message and requires both the second codeword and its check bits to match an independent long division. If the start had been lost or delayed, or stale remainder bits had survived, that comparison would fail.

// File: rtl/crc_enc_pkg.sv
package crc_enc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSG  = 2'd1,
        ST_FCS  = 2'd2,
        ST_FIN  = 2'd3
    } enc_state_t;
endpackage

// File: rtl/crc_enc_lfsr.sv
module crc_enc_lfsr #(
    parameter int          CRC_W    = 5,
    parameter logic [CRC_W-1:0] CRC_POLY = 5'b10101
) (
    input  logic clk,
    input  logic clr,
    input  logic shift,
    input  logic fb_en,
    input  logic bit_in,
    output logic msb
);
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] rem_d;
    logic             fb;

    // Feedback is gated off during the shift-out phase; zeros then enter stage 0.
    assign fb = fb_en & (rem_q[CRC_W-1] ^ bit_in);

    generate
        for (genvar g = 0; g < CRC_W; g++) begin : g_stage
            if (g == 0) begin : g_low
                assign rem_d[g] = CRC_POLY[g] & fb;
            end else if (CRC_POLY[g]) begin : g_tap
                assign rem_d[g] = rem_q[g-1] ^ fb;
            end else begin : g_plain
                assign rem_d[g] = rem_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            rem_q <= '0;
        end else if (shift) begin
            rem_q <= rem_d;
        end
    end

    assign msb = rem_q[CRC_W-1];
endmodule

// File: rtl/crc_enc_ctrl.sv
module crc_enc_ctrl
    import crc_enc_pkg::*;
#(
    parameter int CRC_W   = 5,
    parameter int MSG_LEN = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       din,
    input  logic       din_valid,
    input  logic       rem_msb,
    output logic       lfsr_clr,
    output logic       lfsr_shift,
    output logic       lfsr_fb_en,
    output logic       dout,
    output logic       dout_valid,
    output logic       done,
    output enc_state_t state
);
    localparam int MAX_CNT = (MSG_LEN > CRC_W) ? MSG_LEN : CRC_W;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] MSG_LAST = CNT_W'(MSG_LEN - 1);
    localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(CRC_W - 1);

    enc_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             msg_take;

    assign msg_take = (state_q == ST_MSG) && din_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_MSG;
            ST_MSG:  if (msg_take && cnt_q == MSG_LAST) state_d = ST_FCS;
            ST_FCS:  if (cnt_q == FCS_LAST) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
        endcase
    end

    // State register and phase counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (msg_take || state_q == ST_FCS) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            dout       <= 1'b0;
            dout_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    dout       <= 1'b0;
                    dout_valid <= 1'b0;
                    done       <= 1'b0;
                end
                ST_MSG: begin
                    dout       <= din_valid & din;
                    dout_valid <= din_valid;
                    done       <= 1'b0;
                end
                ST_FCS: begin
                    dout       <= rem_msb;
                    dout_valid <= 1'b1;
                    done       <= 1'b0;
                end
                ST_FIN: begin
                    dout       <= 1'b0;
                    dout_valid <= 1'b0;
                    done       <= 1'b1;
                end
            endcase
        end
    end

    assign lfsr_clr   = rst | ((state_q == ST_IDLE) & start);
    assign lfsr_shift = msg_take | (state_q == ST_FCS);
    assign lfsr_fb_en = (state_q == ST_MSG);
    assign state      = state_q;
endmodule

// File: rtl/crc_serial_enc.sv
module crc_serial_enc
    import crc_enc_pkg::*;
#(
    parameter int               CRC_W    = 5,
    parameter logic [CRC_W-1:0] CRC_POLY = 5'b10101,
    parameter int               MSG_LEN  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic din,
    input  logic din_valid,
    output logic dout,
    output logic dout_valid,
    output logic done
);
    logic       lfsr_clr, lfsr_shift, lfsr_fb_en, rem_msb;
    enc_state_t state;

    crc_enc_ctrl #(
        .CRC_W   (CRC_W),
        .MSG_LEN (MSG_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .din        (din),
        .din_valid  (din_valid),
        .rem_msb    (rem_msb),
        .lfsr_clr   (lfsr_clr),
        .lfsr_shift (lfsr_shift),
        .lfsr_fb_en (lfsr_fb_en),
        .dout       (dout),
        .dout_valid (dout_valid),
        .done       (done),
        .state      (state)
    );

    crc_enc_lfsr #(
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY)
    ) u_lfsr (
        .clk    (clk),
        .clr    (lfsr_clr),
        .shift  (lfsr_shift),
        .fb_en  (lfsr_fb_en),
        .bit_in (din),
        .msb    (rem_msb)
    );
endmodule

// File: rtl/crc_serial_enc_chk.sv
module crc_serial_enc_chk
    import crc_enc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       din_valid,
    input logic       dout,
    input logic       dout_valid,
    input logic       done,
    input enc_state_t state
);
    // R2: an accepted message bit is forwarded one cycle later
    assert_fwd_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MSG && din_valid) |=> (dout_valid && dout == $past(din)));

    // R2: no valid input in the message phase gives no valid output
    assert_gap_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MSG && !din_valid) |=> !dout_valid);

    // R3: check phase emits valid bits every cycle
    assert_fcs_contig_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FCS) |=> dout_valid);

    // R5: done is a single cycle with no valid data alongside
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !dout_valid);

    // R6: once past the message phase, the frame cannot re-enter it before idling
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FCS || state == ST_FIN) |=> (state != ST_MSG));

    // R8: idle produces no output
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> !dout_valid);
endmodule

bind crc_serial_enc crc_serial_enc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .din_valid  (din_valid),
    .dout       (dout),
    .dout_valid (dout_valid),
    .done       (done),
    .state      (state)
);

// File: tb/crc_serial_enc_tb_top.sv
module crc_serial_enc_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 5;
    localparam logic [W-1:0] POLY      = 5'b10101;
    localparam int          MSG        = 10;

    logic clk = 1'b0;
    logic rst, start, din, din_valid;
    logic dout, dout_valid, done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_serial_enc #(.CRC_W(W), .CRC_POLY(POLY), .MSG_LEN(MSG)) dut_i (
        .clk(clk), .rst(rst), .start(start), .din(din), .din_valid(din_valid),
        .dout(dout), .dout_valid(dout_valid), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Long division of msg * x^W by the full generator
    function automatic logic [W-1:0] ref_fcs(input logic [MSG-1:0] m);
        logic [MSG+W-1:0] v;
        logic [W:0]       gen;
        v   = {m, {W{1'b0}}};
        gen = {1'b1, POLY};
        for (int i = MSG + W - 1; i >= W; i--) begin
            if (v[i]) v[i -: W+1] = v[i -: W+1] ^ gen;
        end
        return v[W-1:0];
    endfunction

    // Runs one frame from a negedge; returns at the negedge where done is seen.
    task automatic send_frame(input logic [MSG-1:0] msg, input int gap_at,
                              input bit start_mid, input bit chained,
                              input bit chain_next, input string req);
        logic [W-1:0] fcs = '0;
        int  nv = 0;
        bit  saw_done = 1'b0;
        if (!chained) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R5", "done after pulse", done, 0);
        for (int i = 0; i < MSG; i++) begin
            if (i == gap_at) begin
                din_valid = 1'b0;
                din       = 1'b1;
                @(negedge clk);
                check(dout_valid == 1'b0, "R2", "valid during gap", dout_valid, 0);
            end
            din       = msg[MSG-1-i];
            din_valid = 1'b1;
            if (start_mid && i == 4) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(dout_valid && dout == msg[MSG-1-i], "R2", "message bit",
                  {dout_valid, dout}, {1'b1, msg[MSG-1-i]});
            if (dout_valid) nv++;
        end
        din_valid = 1'b0;
        din       = 1'b0;
        for (int k = 0; k < 4 * W; k++) begin
            if (start_mid && k == 1) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                saw_done = 1'b1;
                check(dout_valid == 1'b0, "R5", "valid with done", dout_valid, 0);
                break;
            end
            if (dout_valid) begin
                fcs = {fcs[W-2:0], dout};
                nv++;
            end
        end
        check(saw_done, "R5", "done seen", saw_done, 1);
        check(nv == MSG + W, "R5", "valid cycle count", nv, MSG + W);
        check(fcs == ref_fcs(msg), req, "check bits", fcs, ref_fcs(msg));
        if (chain_next) start = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; din = 1'b0; din_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!dout_valid && !done && !dout, "R1", "reset outputs",
              {dout_valid, done, dout}, 0);
    endtask

    task automatic t_example();
        logic [MSG-1:0] m = 10'b1010001101;
        check(ref_fcs(m) == 5'b01110, "R4", "reference remainder", ref_fcs(m), 5'b01110);
        send_frame(m, -1, 1'b0, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_patterns();
        send_frame(10'b0000000000, -1, 1'b0, 1'b0, 1'b0, "R3");
        send_frame(10'b1111111111, -1, 1'b0, 1'b0, 1'b0, "R3");
        send_frame(10'b1000000001, -1, 1'b0, 1'b0, 1'b0, "R3");
        send_frame(10'b0110100111, -1, 1'b0, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_gap();
        send_frame(10'b1101001011, 3, 1'b0, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_busy_start();
        send_frame(10'b0101110010, -1, 1'b1, 1'b0, 1'b0, "R6");
        @(negedge clk);
        check(!dout_valid, "R6", "no frame after ignored start", dout_valid, 0);
    endtask

    task automatic t_idle_input();
        din = 1'b1; din_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!dout_valid && !done, "R8", "idle output", {dout_valid, done}, 0);
        end
        din_valid = 1'b0; din = 1'b0;
        send_frame(10'b1010001101, -1, 1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_back_to_back();
        send_frame(10'b1111100000, -1, 1'b0, 1'b0, 1'b1, "R7");
        send_frame(10'b0000011111, -1, 1'b0, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_mid_reset();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        din_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            din = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!dout_valid && !done && !dout, "R1", "mid-frame reset",
              {dout_valid, done, dout}, 0);
        send_frame(10'b0011001100, -1, 1'b0, 1'b0, 1'b0, "R1");
    endtask

    initial begin
        t_reset();
        t_example();
        t_patterns();
        t_gap();
        t_busy_start();
        t_idle_input();
        t_back_to_back();
        t_mid_reset();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule